// File: doc/BRIEF.md
# Single-Precision Compare and Predicate Unit

This block orders two 32-bit binary floating-point operands and reports the outcome two ways. The first is a one-hot condition code with one bit each for less, equal, greater and unordered. The second is the true/false answer to a predicate that the caller selects on each compare. An invalid flag goes with the answer. It is raised when an unordered result meets a predicate that asks for signalling, or when either operand is a signaling NaN.

The ordering path is combinational. Each operand is classified, and the two magnitudes are compared as unsigned integers over the exponent and fraction fields. The order is flipped when both signs are negative. A parameter adds one output register stage, which suits timing closure at a registered pipeline boundary. The predicate is a small bit mask over the four relations plus a signal-on-unordered bit. Any of the usual comparison operators, and their negations, can therefore be selected without a decoder table.

Top module: `fp_compare_unit`

## Requirements
- R1: Exactly one bit of `cc` is set after any compare: bit 0 = less, bit 1 = equal, bit 2 = greater, bit 3 = unordered.
- R2: If either operand is a NaN (exponent all ones, fraction nonzero), `cc` reports unordered, and this includes a NaN compared with itself.
- R3: +0 (0x00000000) and -0 (0x80000000) compare equal in either order.
- R4: Ordered operands follow the real-number order, with -infinity below every finite value and +infinity above it; denormals order above zero; two negative operands order by reversed magnitude.
- R5: `pred_true` is the OR of `cc` masked by `pred_sel[3:0]`, where mask bit 0 = less, 1 = equal, 2 = greater, 3 = unordered, XORed with `pred_neg`.
- R6: `pred_neg` inverts `pred_true` and leaves `invalid` unchanged.
- R7: With quiet NaN operands, `invalid` is set exactly when `pred_sel[4]` (signal on unordered) is 1.
- R8: A signaling NaN operand (exponent all ones, fraction MSB 0, fraction nonzero) sets `invalid` for every predicate.
- R9: When neither operand is a NaN, `invalid` is 0 whatever the predicate.
- R10: With `REG_OUT` = 1, outputs appear one clock edge after the inputs, and synchronous `rst` clears `cc`, `pred_true` and `invalid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand, single precision |
| op_b | input | 32 | Second operand, single precision |
| pred_sel | input | 5 | Relation mask [3:0] and signal-on-unordered bit [4] |
| pred_neg | input | 1 | Invert the predicate answer |
| cc | output | 4 | One-hot condition code {unord, gt, eq, lt} |
| pred_true | output | 1 | Predicate answer |
| invalid | output | 1 | Invalid-operation flag |

## Verification
Operand pairs cover positive finite values, pairs of negatives, infinities against the largest finite value, a denormal against zero, and both signs of zero. These separate the magnitude compare, the sign flip and the zero special case. Quiet and signaling NaNs are paired with signalling and non-signalling predicates, with and without negation. This shows whether the invalid flag follows the predicate's signal bit, the NaN kind and the negate input independently. One sample taken before the clock edge confirms the register latency.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int CC_W    = 4;
  localparam int CC_LT   = 0;
  localparam int CC_EQ   = 1;
  localparam int CC_GT   = 2;
  localparam int CC_UN   = 3;
  localparam int SEL_W   = 5;
  localparam int SEL_SIG = 4;

  typedef struct packed {
    logic sign;
    logic is_nan;
    logic is_snan;
    logic is_zero;
  } fp_class_t;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0]   val,
  output fp_class_t               cls,
  output logic [EXP_W+FRAC_W-1:0] mag
);
  localparam int W = EXP_W + FRAC_W + 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max;
  logic              frac_nz;

  assign exp_f   = val[W-2 -: EXP_W];
  assign frac_f  = val[FRAC_W-1:0];
  assign exp_max = &exp_f;
  assign frac_nz = |frac_f;
  assign mag     = val[W-2:0];

  always_comb begin
    cls.sign    = val[W-1];
    cls.is_nan  = exp_max && frac_nz;
    cls.is_snan = exp_max && frac_nz && !frac_f[FRAC_W-1];
    cls.is_zero = !(|mag);
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
#(
  parameter int MAG_W = 31
) (
  input  fp_class_t        cls_a,
  input  fp_class_t        cls_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  output logic [CC_W-1:0]  cc
);
  logic mag_lt;
  logic mag_eq;

  assign mag_lt = mag_a < mag_b;
  assign mag_eq = mag_a == mag_b;

  always_comb begin
    cc = '0;
    if (cls_a.is_nan || cls_b.is_nan)
      cc[CC_UN] = 1'b1;
    else if (cls_a.is_zero && cls_b.is_zero)
      cc[CC_EQ] = 1'b1;
    else if (cls_a.sign != cls_b.sign) begin
      if (cls_a.sign) cc[CC_LT] = 1'b1;
      else            cc[CC_GT] = 1'b1;
    end
    else if (mag_eq)
      cc[CC_EQ] = 1'b1;
    else if (mag_lt ^ cls_a.sign)
      cc[CC_LT] = 1'b1;
    else
      cc[CC_GT] = 1'b1;
  end
endmodule

// File: rtl/fpcmp_predicate.sv
module fpcmp_predicate
  import fpcmp_pkg::*;
(
  input  logic [CC_W-1:0]  cc,
  input  logic [SEL_W-1:0] sel,
  input  logic             neg,
  input  logic             snan_any,
  output logic             result,
  output logic             invalid
);
  logic hit;

  assign hit     = |(cc & sel[CC_W-1:0]);
  assign result  = hit ^ neg;
  assign invalid = snan_any || (cc[CC_UN] && sel[SEL_SIG]);
endmodule

// File: rtl/fp_compare_unit.sv
module fp_compare_unit
  import fpcmp_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [EXP_W+FRAC_W:0]  op_a,
  input  logic [EXP_W+FRAC_W:0]  op_b,
  input  logic [SEL_W-1:0]       pred_sel,
  input  logic                   pred_neg,
  output logic [CC_W-1:0]        cc,
  output logic                   pred_true,
  output logic                   invalid
);
  localparam int MAG_W = EXP_W + FRAC_W;

  fp_class_t        cls_a, cls_b;
  logic [MAG_W-1:0] mag_a, mag_b;
  logic [CC_W-1:0]  cc_c;
  logic             pred_c;
  logic             inv_c;
  logic             any_nan;
  logic             any_snan;

  fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
    .val(op_a), .cls(cls_a), .mag(mag_a));
  fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
    .val(op_b), .cls(cls_b), .mag(mag_b));

  assign any_nan  = cls_a.is_nan  || cls_b.is_nan;
  assign any_snan = cls_a.is_snan || cls_b.is_snan;

  fpcmp_order #(.MAG_W(MAG_W)) u_order (
    .cls_a(cls_a), .cls_b(cls_b), .mag_a(mag_a), .mag_b(mag_b), .cc(cc_c));

  fpcmp_predicate u_pred (
    .cc(cc_c), .sel(pred_sel), .neg(pred_neg), .snan_any(any_snan),
    .result(pred_c), .invalid(inv_c));

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          cc        <= '0;
          pred_true <= 1'b0;
          invalid   <= 1'b0;
        end else begin
          cc        <= cc_c;
          pred_true <= pred_c;
          invalid   <= inv_c;
        end
      end

      // R10: outputs follow the combinational result one edge later
      a_r10_latency: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cc == $past(cc_c) && pred_true == $past(pred_c)
                         && invalid == $past(inv_c)));
    end else begin : g_comb
      assign cc        = cc_c;
      assign pred_true = pred_c;
      assign invalid   = inv_c;
    end
  endgenerate

  // R1: exactly one relation reported
  a_r1_cc_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(cc_c) == 1);
  // R2: any NaN gives unordered
  a_r2_nan_unordered: assert property (@(posedge clk) disable iff (rst)
    any_nan |-> cc_c[CC_UN]);
  // R3: two zeros of any sign are equal
  a_r3_zero_equal: assert property (@(posedge clk) disable iff (rst)
    (cls_a.is_zero && cls_b.is_zero) |-> cc_c[CC_EQ]);
  // R8: signaling NaN always flags invalid
  a_r8_snan_invalid: assert property (@(posedge clk) disable iff (rst)
    any_snan |-> inv_c);
  // R9: ordered operands never flag invalid
  a_r9_no_invalid_ordered: assert property (@(posedge clk) disable iff (rst)
    !any_nan |-> !inv_c);
endmodule

// File: tb/fp_compare_unit_test.sv
module fp_compare_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [4:0]  pred_sel = '0;
  logic        pred_neg = 1'b0;
  logic [3:0]  cc;
  logic        pred_true;
  logic        invalid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [3:0] LT = 4'b0001, EQ = 4'b0010, GT = 4'b0100, UN = 4'b1000;
  localparam logic [4:0] P_EQ = 5'b00010, P_NE = 5'b01101, P_GT = 5'b10100,
                         P_GE = 5'b10110, P_LT = 5'b10001, P_LE = 5'b10011,
                         P_UN = 5'b01000;
  localparam logic [31:0] ONE = 32'h3F800000, TWO = 32'h40000000,
                          M_ONE = 32'hBF800000, M_TWO = 32'hC0000000,
                          P_ZERO = 32'h0, M_ZERO = 32'h80000000,
                          P_INF = 32'h7F800000, M_INF = 32'hFF800000,
                          MAXF = 32'h7F7FFFFF, QNAN = 32'h7FC00000,
                          SNAN = 32'h7F800001, DENORM = 32'h00000001;

  always #2 clk = ~clk;

  fp_compare_unit uut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .pred_sel(pred_sel),
    .pred_neg(pred_neg), .cc(cc), .pred_true(pred_true), .invalid(invalid));

  task automatic check(input string req, input logic [3:0] e_cc,
                       input logic e_res, input logic e_inv);
    n_chk++;
    if (cc !== e_cc || pred_true !== e_res || invalid !== e_inv) begin
      n_bad++;
      $display("FAIL %s: cc=%b res=%b inv=%b expected cc=%b res=%b inv=%b",
               req, cc, pred_true, invalid, e_cc, e_res, e_inv);
    end
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b,
                     input logic [4:0] sel, input logic neg);
    @(negedge clk);
    op_a = a; op_b = b; pred_sel = sel; pred_neg = neg;
    @(negedge clk);
  endtask

  task automatic t_reset();
    op_a = ONE; op_b = TWO; pred_sel = P_LT;
    repeat (3) @(negedge clk);
    check("R10 reset", 4'b0000, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_finite_order();
    run(ONE, TWO, P_LT, 1'b0);   check("R4 1<2", LT, 1'b1, 1'b0);
    run(TWO, ONE, P_GE, 1'b0);   check("R4 2>=1", GT, 1'b1, 1'b0);
    run(M_ONE, M_TWO, P_GT, 1'b0); check("R4 -1>-2", GT, 1'b1, 1'b0);
    run(M_TWO, ONE, P_LE, 1'b0); check("R4 -2<1", LT, 1'b1, 1'b0);
    run(DENORM, P_ZERO, P_GT, 1'b0); check("R4 denorm>0", GT, 1'b1, 1'b0);
    run(ONE, ONE, P_EQ, 1'b0);   check("R1 equal", EQ, 1'b1, 1'b0);
  endtask

  task automatic t_infinity();
    run(M_INF, MAXF, P_LT, 1'b0); check("R4 -inf<max", LT, 1'b1, 1'b0);
    run(P_INF, MAXF, P_GT, 1'b0); check("R4 +inf>max", GT, 1'b1, 1'b0);
    run(P_INF, P_INF, P_EQ, 1'b0); check("R4 inf=inf", EQ, 1'b1, 1'b0);
  endtask

  task automatic t_zero();
    run(P_ZERO, M_ZERO, P_EQ, 1'b0); check("R3 +0=-0", EQ, 1'b1, 1'b0);
    run(M_ZERO, P_ZERO, P_LT, 1'b0); check("R3 -0 not<+0", EQ, 1'b0, 1'b0);
  endtask

  task automatic t_quiet_nan();
    run(QNAN, QNAN, P_EQ, 1'b0); check("R2 nan self", UN, 1'b0, 1'b0);
    run(QNAN, ONE, P_NE, 1'b0);  check("R5 ne on nan", UN, 1'b1, 1'b0);
    run(ONE, QNAN, P_UN, 1'b0);  check("R5 unord test", UN, 1'b1, 1'b0);
    run(QNAN, ONE, P_LT, 1'b0);  check("R7 lt signals", UN, 1'b0, 1'b1);
    run(ONE, QNAN, P_GE, 1'b0);  check("R7 ge signals", UN, 1'b0, 1'b1);
  endtask

  task automatic t_negate();
    run(QNAN, ONE, P_LT, 1'b1);  check("R6 not-lt nan", UN, 1'b1, 1'b1);
    run(ONE, ONE, P_EQ, 1'b1);   check("R6 not-eq", EQ, 1'b0, 1'b0);
    run(ONE, TWO, P_GT, 1'b1);   check("R6 not-gt", LT, 1'b1, 1'b0);
  endtask

  task automatic t_snan();
    run(SNAN, ONE, P_EQ, 1'b0);  check("R8 snan eq", UN, 1'b0, 1'b1);
    run(ONE, SNAN, P_UN, 1'b1);  check("R8 snan not-un", UN, 1'b0, 1'b1);
  endtask

  task automatic t_no_invalid();
    run(M_INF, P_INF, P_LE, 1'b0); check("R9 inf le", LT, 1'b1, 1'b0);
    run(TWO, ONE, P_LT, 1'b1);     check("R9 not-lt", GT, 1'b1, 1'b0);
  endtask

  task automatic t_latency();
    run(ONE, TWO, P_LT, 1'b0);
    @(negedge clk);
    op_a = TWO; op_b = ONE;
    #1;
    check("R10 before edge", LT, 1'b1, 1'b0);
    @(negedge clk);
    check("R10 after edge", GT, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_finite_order();
    t_infinity();
    t_zero();
    t_quiet_nan();
    t_negate();
    t_snan();
    t_no_invalid();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule